// File: doc/BRIEF.md
# Configurable Instruction Cache and SRAM Array

This block is the instruction-side memory of a processor core. It is built from four identical storage blocks. Through a configuration port, each block is set to one of two modes. In the first mode it is a direct-mapped instruction cache of 64 words of 32 bits. In the second mode it is a 512-byte on-chip SRAM window that can be placed at any 512-byte-aligned address. Blocks in cache mode are searched together as the ways of one set-associative cache, so the cache has up to four ways. Any cache block can be locked, which freezes what it holds.

The core issues word fetches on the fetch port. A hit in an SRAM window or in a cache way returns the word one cycle later. On a miss the block drops `fetchReady` and raises a single-word refill request toward external memory. When the refill is acknowledged, the word goes to the core and, when possible, into an unlocked cache way chosen round-robin. A separate preload port writes words into the SRAM windows, so they can hold code or operands. Configuration can change at any time, for example on a task switch.

Top module: `icache_sram_array`

## Requirements
- R1: After reset, `fetchReady` is 1, `rspValid` is 0 and `refillReq` is 0. Every block starts disabled, in cache mode and unlocked, so every fetch misses and is refilled.
- R2: A fetch that hits a cache way is accepted while `fetchReady` is 1. On the next cycle `rspValid`=1 and `rspHit`=1, and `rspData` is the word stored by the earlier refill of that address.
- R3: Suppose a block is enabled, in SRAM mode (`cfgSram`=1) and has base field B, where `cfgBase` gives address bits [31:9]. That block hits every fetch whose bits [31:9] equal B, and returns the word at offset bits [8:2]. Preload writes (`ldWe`) land in the SRAM block whose window holds `ldAddr`. The base may be changed at any time.
- R4: When an address lies in an SRAM window and is also present in a cache way, the SRAM word is returned.
- R5: Address bits [1:0] take no part in lookup, refill or preload, so any byte offset returns the same word.
- R6: Cache-mode blocks act as ways. The index is bits [7:2] and the tag is bits [31:8]. Two enabled cache blocks keep two lines with the same index at the same time.
- R7: A locked block (`cfgLock`=1) is never chosen for a refill. If no enabled, unlocked cache block exists, the refill word is still returned with `rspHit`=0, but it is not stored.
- R8: A `cfgInvAll` pulse clears every valid bit of each unlocked block at that clock edge. Locked blocks keep their lines.
- R9: A configuration write that changes a block's mode clears every valid bit of that block.
- R10: A disabled block neither hits nor receives refills. Clearing and setting the enable bit leave the block's stored lines intact.
- R11: The victim is the first enabled, unlocked cache block at or after a 2-bit round-robin pointer, wrapping past block 3. After each stored refill the pointer becomes victim+1, so two such blocks alternate.
- R12: On a miss, `fetchReady` falls and `refillReq` rises with `refillAddr` equal to the fetch address with bits [1:0] cleared. Both hold until `refillAck`. The following cycle gives `rspValid`=1, `rspHit`=0, `rspData`=`refillData` and `fetchReady`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchReq | input | 1 | Fetch request, taken when fetchReady is 1 |
| fetchAddr | input | 32 | Fetch byte address |
| fetchReady | output | 1 | High when a new fetch can be accepted |
| rspValid | output | 1 | One-cycle pulse: rspData holds the fetched word |
| rspHit | output | 1 | With rspValid: 1 for an array hit, 0 for a refill |
| rspData | output | 32 | Fetched word |
| refillReq | output | 1 | External single-word read request |
| refillAddr | output | 32 | Word-aligned refill address |
| refillAck | input | 1 | Refill word present on refillData |
| refillData | input | 32 | Refill word |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Block selected by the configuration write |
| cfgSram | input | 1 | 1 = SRAM mode, 0 = cache mode |
| cfgEnable | input | 1 | Block enable |
| cfgLock | input | 1 | Freeze cache contents |
| cfgBase | input | 23 | SRAM window base, address bits [31:9] |
| cfgInvAll | input | 1 | Global invalidate pulse |
| ldWe | input | 1 | SRAM preload write strobe |
| ldAddr | input | 32 | Preload byte address |
| ldData | input | 32 | Preload word |

## Verification
Corrupted tag, valid or pointer state shows up at the ports within one fetch. A line that should hit instead raises `refillReq` on the very next cycle. A line that should miss returns stale `rspData` with `rspHit`=1 instead. A wrong round-robin pointer or a lock that is not honoured changes which of two lines with the same index survives a third refill, and that is seen when each line is fetched again. Priority or window-decode errors show up as external data returned where the SRAM word was expected, or the other way round.

// File: rtl/icsa_pkg.sv
package icsa_pkg;
  localparam int NUM_BLK = 4;
  localparam int WAY_W   = $clog2(NUM_BLK);

  typedef enum logic {ST_IDLE, ST_REFILL} ctrl_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             lookup;   // accept fetch, read arrays
    logic             fill;     // refill word arrived
    logic             store;    // refill word is written into a way
    logic [WAY_W-1:0] way;      // victim way for store
  } ctrl_strobe_t;
endpackage

// File: rtl/icsa_block.sv
module icsa_block #(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 6,
  parameter int SIDX_W  = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWr,
  input  logic                      cfgSram,
  input  logic                      cfgEnable,
  input  logic                      cfgLock,
  input  logic [WADDR_W-SIDX_W-1:0] cfgBase,
  input  logic                      invAll,
  input  logic                      lookup,
  input  logic [WADDR_W-1:0]        lkWord,
  input  logic                      fillEn,
  input  logic [WADDR_W-1:0]        fillWord,
  input  logic [DATA_W-1:0]         fillData,
  input  logic                      ldWe,
  input  logic [WADDR_W-1:0]        ldWord,
  input  logic [DATA_W-1:0]         ldData,
  output logic                      sramHit,
  output logic                      cacheHit,
  output logic                      cacheWay,
  output logic [DATA_W-1:0]         rdWord
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam int SWORDS  = 1 << SIDX_W;
  localparam int TAG_W   = WADDR_W - IDX_W;
  localparam int BASE_W  = WADDR_W - SIDX_W;

  logic              modeSram, enabled, locked;
  logic [BASE_W-1:0] base;
  logic [DATA_W-1:0] mem [SWORDS];
  logic [TAG_W-1:0]  tags [ENTRIES];
  logic [ENTRIES-1:0] valid;

  logic [IDX_W-1:0]  lkIdx, fillIdx;
  logic [SIDX_W-1:0] rdIdx;
  logic              ldHit;

  assign lkIdx   = lkWord[IDX_W-1:0];
  assign fillIdx = fillWord[IDX_W-1:0];
  assign rdIdx   = modeSram ? lkWord[SIDX_W-1:0] : SIDX_W'(lkIdx);

  assign sramHit  = enabled && modeSram && (lkWord[WADDR_W-1:SIDX_W] == base);
  assign cacheHit = enabled && !modeSram && valid[lkIdx] &&
                    (tags[lkIdx] == lkWord[WADDR_W-1:IDX_W]);
  assign cacheWay = enabled && !modeSram && !locked;
  assign ldHit    = ldWe && enabled && modeSram && (ldWord[WADDR_W-1:SIDX_W] == base);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeSram <= 1'b0;
      enabled  <= 1'b0;
      locked   <= 1'b0;
      base     <= '0;
    end else if (cfgWr) begin
      modeSram <= cfgSram;
      enabled  <= cfgEnable;
      locked   <= cfgLock;
      base     <= cfgBase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                              valid <= '0;
    else if (cfgWr && cfgSram != modeSram)  valid <= '0;
    else if (invAll && !locked)             valid <= '0;
    else if (fillEn)                        valid[fillIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fillEn) tags[fillIdx] <= fillWord[WADDR_W-1:IDX_W];
  end

  always_ff @(posedge clk) begin
    if (fillEn)      mem[SIDX_W'(fillIdx)] <= fillData;
    else if (ldHit)  mem[ldWord[SIDX_W-1:0]] <= ldData;
    if (lookup)      rdWord <= mem[rdIdx];
  end
endmodule

// File: rtl/icsa_ctrl.sv
module icsa_ctrl
  import icsa_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               fetchReq,
  input  logic               hitAny,
  input  logic [NUM_BLK-1:0] cacheWayV,
  input  logic               refillAck,
  output ctrl_strobe_t       strobe,
  output logic               fetchReady,
  output logic               refillReq,
  output logic               rspValid,
  output logic               rspHit
);
  ctrl_state_t      state;
  logic [WAY_W-1:0] rrPtr, victim;
  logic             victimFound;

  always_comb begin
    victim      = '0;
    victimFound = 1'b0;
    for (int k = 0; k < NUM_BLK; k++) begin
      logic [WAY_W-1:0] cand;
      cand = rrPtr + WAY_W'(k);
      if (!victimFound && cacheWayV[cand]) begin
        victim      = cand;
        victimFound = 1'b1;
      end
    end
  end

  assign fetchReady    = (state == ST_IDLE);
  assign refillReq     = (state == ST_REFILL);
  assign strobe.lookup = fetchReady && fetchReq;
  assign strobe.fill   = refillReq && refillAck;
  assign strobe.store  = strobe.fill && victimFound;
  assign strobe.way    = victim;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      rrPtr    <= '0;
      rspValid <= 1'b0;
      rspHit   <= 1'b0;
    end else begin
      rspValid <= (strobe.lookup && hitAny) || strobe.fill;
      rspHit   <= strobe.lookup && hitAny;
      if (strobe.lookup && !hitAny) state <= ST_REFILL;
      else if (strobe.fill)         state <= ST_IDLE;
      if (strobe.store)             rrPtr <= victim + WAY_W'(1);
    end
  end
endmodule

// File: rtl/icsa_datapath.sv
module icsa_datapath
  import icsa_pkg::*;
#(
  parameter int WADDR_W = 30,
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 6,
  parameter int SIDX_W  = 7
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobe_t              strobe,
  input  logic [WADDR_W-1:0]        fetchWord,
  input  logic                      cfgWe,
  input  logic [WAY_W-1:0]          cfgSel,
  input  logic                      cfgSram,
  input  logic                      cfgEnable,
  input  logic                      cfgLock,
  input  logic [WADDR_W-SIDX_W-1:0] cfgBase,
  input  logic                      cfgInvAll,
  input  logic                      ldWe,
  input  logic [WADDR_W-1:0]        ldWord,
  input  logic [DATA_W-1:0]         ldData,
  input  logic [DATA_W-1:0]         refillData,
  output logic                      hitAny,
  output logic [NUM_BLK-1:0]        cacheWayV,
  output logic [WADDR_W-1:0]        missWord,
  output logic [DATA_W-1:0]         rspData
);
  logic [NUM_BLK-1:0] sramHitV, cacheHitV;
  logic [DATA_W-1:0]  rdWordA [NUM_BLK];
  logic [WAY_W-1:0]   hitWay, selQ;
  logic               useFillQ;
  logic [DATA_W-1:0]  fillQ;

  for (genvar b = 0; b < NUM_BLK; b++) begin : g_blk
    icsa_block #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SIDX_W(SIDX_W)) u_blk (
      .clk(clk), .rstN(rstN),
      .cfgWr(cfgWe && (cfgSel == WAY_W'(b))),
      .cfgSram(cfgSram), .cfgEnable(cfgEnable), .cfgLock(cfgLock), .cfgBase(cfgBase),
      .invAll(cfgInvAll),
      .lookup(strobe.lookup), .lkWord(fetchWord),
      .fillEn(strobe.store && (strobe.way == WAY_W'(b))),
      .fillWord(missWord), .fillData(refillData),
      .ldWe(ldWe), .ldWord(ldWord), .ldData(ldData),
      .sramHit(sramHitV[b]), .cacheHit(cacheHitV[b]), .cacheWay(cacheWayV[b]),
      .rdWord(rdWordA[b])
    );
  end

  // SRAM windows outrank cache ways; lower block index wins within a class
  always_comb begin
    hitWay = '0;
    for (int i = NUM_BLK - 1; i >= 0; i--) if (cacheHitV[i]) hitWay = WAY_W'(i);
    for (int i = NUM_BLK - 1; i >= 0; i--) if (sramHitV[i])  hitWay = WAY_W'(i);
  end
  assign hitAny = |{sramHitV, cacheHitV};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      missWord <= '0;
      selQ     <= '0;
      useFillQ <= 1'b0;
      fillQ    <= '0;
    end else if (strobe.lookup) begin
      missWord <= fetchWord;
      selQ     <= hitWay;
      useFillQ <= 1'b0;
    end else if (strobe.fill) begin
      fillQ    <= refillData;
      useFillQ <= 1'b1;
    end
  end

  assign rspData = useFillQ ? fillQ : rdWordA[selQ];
endmodule

// File: rtl/icache_sram_array.sv
module icache_sram_array
  import icsa_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6,
  parameter int SIDX_W = 7
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fetchReq,
  input  logic [ADDR_W-1:0]        fetchAddr,
  output logic                     fetchReady,
  output logic                     rspValid,
  output logic                     rspHit,
  output logic [DATA_W-1:0]        rspData,
  output logic                     refillReq,
  output logic [ADDR_W-1:0]        refillAddr,
  input  logic                     refillAck,
  input  logic [DATA_W-1:0]        refillData,
  input  logic                     cfgWe,
  input  logic [1:0]               cfgSel,
  input  logic                     cfgSram,
  input  logic                     cfgEnable,
  input  logic                     cfgLock,
  input  logic [ADDR_W-SIDX_W-3:0] cfgBase,
  input  logic                     cfgInvAll,
  input  logic                     ldWe,
  input  logic [ADDR_W-1:0]        ldAddr,
  input  logic [DATA_W-1:0]        ldData
);
  localparam int WADDR_W = ADDR_W - 2;

  ctrl_strobe_t       strobe;
  logic               hitAny;
  logic [NUM_BLK-1:0] cacheWayV;
  logic [WADDR_W-1:0] missWord;
  logic               unusedLowBits;

  assign unusedLowBits = ^{fetchAddr[1:0], ldAddr[1:0]};

  icsa_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .hitAny(hitAny),
    .cacheWayV(cacheWayV), .refillAck(refillAck), .strobe(strobe),
    .fetchReady(fetchReady), .refillReq(refillReq),
    .rspValid(rspValid), .rspHit(rspHit)
  );

  icsa_datapath #(.WADDR_W(WADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SIDX_W(SIDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .fetchWord(fetchAddr[ADDR_W-1:2]),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgSram(cfgSram), .cfgEnable(cfgEnable),
    .cfgLock(cfgLock), .cfgBase(cfgBase), .cfgInvAll(cfgInvAll),
    .ldWe(ldWe), .ldWord(ldAddr[ADDR_W-1:2]), .ldData(ldData),
    .refillData(refillData),
    .hitAny(hitAny), .cacheWayV(cacheWayV), .missWord(missWord), .rspData(rspData)
  );

  assign refillAddr = {missWord, 2'b00};
endmodule

// File: rtl/icsa_checker.sv
module icsa_checker #(parameter int ADDR_W = 32) (
  input logic              clk,
  input logic              rstN,
  input logic              fetchReq,
  input logic              fetchReady,
  input logic              hitAny,
  input logic              rspValid,
  input logic              rspHit,
  input logic              refillReq,
  input logic              refillAck,
  input logic [ADDR_W-1:0] refillAddr
);
  AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    fetchReady && fetchReq && hitAny |=> rspValid && rspHit && !refillReq); // R2
  AST_MISS_REQUESTS_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    fetchReady && fetchReq && !hitAny |=> refillReq && !rspValid); // R12
  AST_READY_LOW_IN_REFILL: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |-> !fetchReady); // R12
  AST_REFILL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    refillReq && !refillAck |=> refillReq && $stable(refillAddr)); // R12
  AST_REFILL_RESPONDS: assert property (@(posedge clk) disable iff (!rstN)
    refillReq && refillAck |=> rspValid && !rspHit && fetchReady); // R12
  AST_REFILL_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    refillReq |-> refillAddr[1:0] == 2'b00); // R5
endmodule

bind icache_sram_array icsa_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchReady(fetchReady),
  .hitAny(hitAny), .rspValid(rspValid), .rspHit(rspHit),
  .refillReq(refillReq), .refillAck(refillAck), .refillAddr(refillAddr)
);

// File: tb/sim_icache_sram_array.sv
`timescale 1ns/1ps
module sim_icache_sram_array;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchReady, rspValid, rspHit, refillReq;
  logic [31:0] rspData, refillAddr;
  logic        refillAck = 1'b0;
  logic [31:0] refillData = '0;
  logic        cfgWe = 1'b0, cfgSram = 1'b0, cfgEnable = 1'b0, cfgLock = 1'b0, cfgInvAll = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [22:0] cfgBase = '0;
  logic        ldWe = 1'b0;
  logic [31:0] ldAddr = '0, ldData = '0;

  int checks = 0, failures = 0, refillCount = 0, readyBad = 0, waitCnt = 0;
  logic [31:0] lastRefill = '0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  icache_sram_array u0 (.*);

  function automatic logic [31:0] extWord(input logic [31:0] a);
    return ~{a[31:2], 2'b00} ^ 32'h1357_9BDF;
  endfunction
  function automatic logic [31:0] sramWord(input logic [31:0] a);
    return {a[31:2], 2'b00} + 32'h0BAD_0000;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // external memory: acknowledges each refill two cycles after it is raised
  initial begin
    forever begin
      @(negedge clk);
      if (refillAck) begin
        refillAck = 1'b0;
        waitCnt = 0;
      end else if (refillReq) begin
        if (fetchReady) readyBad++;
        if (waitCnt == 2) begin
          refillAck  = 1'b1;
          refillData = extWord(refillAddr);
          refillCount++;
          lastRefill = refillAddr;
        end else waitCnt++;
      end
    end
  end

  task automatic setBlk(input int sel, input bit sram, input bit en, input bit lock,
                        input logic [22:0] base);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = 2'(sel); cfgSram = sram; cfgEnable = en; cfgLock = lock; cfgBase = base;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic invAll();
    @(negedge clk) cfgInvAll = 1'b1;
    @(negedge clk) cfgInvAll = 1'b0;
  endtask

  task automatic doFetch(input logic [31:0] a, output logic [31:0] d, output logic h,
                         output int lat);
    @(negedge clk);
    fetchReq = 1'b1; fetchAddr = a;
    @(negedge clk);
    fetchReq = 1'b0;
    lat = 1;
    while (!rspValid && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    d = rspData; h = rspHit;
  endtask

  task automatic expectFetch(input logic [31:0] a, input bit expHit, input logic [31:0] expData,
                             input string req);
    logic [31:0] d; logic h; int lat; int rc;
    rc = refillCount;
    doFetch(a, d, h, lat);
    chk(h == expHit, req, "rspHit", 32'(h), 32'(expHit));
    chk(d == expData, req, "rspData", d, expData);
    if (expHit) chk(lat == 1 && refillCount == rc, req, "hit latency", 32'(lat), 32'd1);
    else        chk(refillCount == rc + 1, req, "refill count", 32'(refillCount - rc), 32'd1);
  endtask

  // kind: 0 = miss (external word), 1 = cache hit, 2 = SRAM hit
  localparam logic [33:0] VEC [9] = '{
    {2'd2, 32'h0001_0000}, {2'd2, 32'h0001_01FC}, {2'd2, 32'h0001_0123},
    {2'd0, 32'h0001_0200}, {2'd0, 32'h0000_3040}, {2'd1, 32'h0000_3040},
    {2'd0, 32'h0000_3140}, {2'd1, 32'h0000_3040}, {2'd1, 32'h0000_3140}
  };

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'(checks), 32'h0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fetchReady == 1'b1, "R1", "reset fetchReady", 32'(fetchReady), 32'd1);
    chk(rspValid == 1'b0, "R1", "reset rspValid", 32'(rspValid), 32'd0);
    chk(refillReq == 1'b0, "R1", "reset refillReq", 32'(refillReq), 32'd0);
    rstN = 1'b1;

    // R1: no block active after reset, nothing is stored
    expectFetch(32'h0000_0100, 1'b0, extWord(32'h0000_0100), "R1");
    expectFetch(32'h0000_0100, 1'b0, extWord(32'h0000_0100), "R1");

    // block0 SRAM at 0x10000, blocks 1 and 2 cache, block3 off
    setBlk(0, 1'b1, 1'b1, 1'b0, 23'h80);
    setBlk(1, 1'b0, 1'b1, 1'b0, 23'h0);
    setBlk(2, 1'b0, 1'b1, 1'b0, 23'h0);
    setBlk(3, 1'b0, 1'b0, 1'b0, 23'h0);
    for (int i = 0; i < 128; i++) begin
      @(negedge clk);
      ldWe = 1'b1; ldAddr = 32'h0001_0000 + 32'(4 * i); ldData = sramWord(ldAddr);
    end
    @(negedge clk) ldWe = 1'b0;

    for (int v = 0; v < 9; v++) begin
      logic [31:0] a;
      a = VEC[v][31:0];
      case (VEC[v][33:32])
        2'd2:    expectFetch(a, 1'b1, sramWord(a), "R3");
        2'd1:    expectFetch(a, 1'b1, extWord(a), "R2/R6");
        default: expectFetch(a, 1'b0, extWord(a), "R12");
      endcase
    end

    // R5: byte offset ignored on a cache hit
    expectFetch(32'h0000_3142, 1'b1, extWord(32'h0000_3140), "R5");

    // R4: move SRAM window over cached lines, SRAM word wins
    setBlk(0, 1'b1, 1'b1, 1'b0, 23'h18);
    @(negedge clk); ldWe = 1'b1; ldAddr = 32'h0000_3040; ldData = sramWord(32'h0000_3040);
    @(negedge clk); ldWe = 1'b0;
    expectFetch(32'h0000_3040, 1'b1, sramWord(32'h0000_3040), "R4");
    setBlk(0, 1'b1, 1'b1, 1'b0, 23'h80);
    expectFetch(32'h0000_3040, 1'b1, extWord(32'h0000_3040), "R3");

    // R8 / R11: invalidate, then three lines on one index over two ways
    invAll();
    expectFetch(32'h0000_3040, 1'b0, extWord(32'h0000_3040), "R8");
    expectFetch(32'h0000_3140, 1'b0, extWord(32'h0000_3140), "R11");
    expectFetch(32'h0000_3240, 1'b0, extWord(32'h0000_3240), "R11");
    expectFetch(32'h0000_3140, 1'b1, extWord(32'h0000_3140), "R11");
    expectFetch(32'h0000_3240, 1'b1, extWord(32'h0000_3240), "R11");
    expectFetch(32'h0000_3040, 1'b0, extWord(32'h0000_3040), "R11");

    // R7: both cache ways locked
    setBlk(1, 1'b0, 1'b1, 1'b1, 23'h0);
    setBlk(2, 1'b0, 1'b1, 1'b1, 23'h0);
    expectFetch(32'h0000_3340, 1'b0, extWord(32'h0000_3340), "R7");
    expectFetch(32'h0000_3340, 1'b0, extWord(32'h0000_3340), "R7");
    expectFetch(32'h0000_3040, 1'b1, extWord(32'h0000_3040), "R7");

    // R8: locked ways survive invalidate, unlocked ones do not
    invAll();
    expectFetch(32'h0000_3240, 1'b1, extWord(32'h0000_3240), "R8");
    setBlk(1, 1'b0, 1'b1, 1'b0, 23'h0);
    setBlk(2, 1'b0, 1'b1, 1'b0, 23'h0);
    invAll();
    expectFetch(32'h0000_3240, 1'b0, extWord(32'h0000_3240), "R8");
    expectFetch(32'h0000_3240, 1'b1, extWord(32'h0000_3240), "R2");

    // R9: mode change clears the ways
    setBlk(1, 1'b1, 1'b0, 1'b0, 23'h7FFFFF);
    setBlk(2, 1'b1, 1'b0, 1'b0, 23'h7FFFFF);
    setBlk(1, 1'b0, 1'b1, 1'b0, 23'h0);
    setBlk(2, 1'b0, 1'b1, 1'b0, 23'h0);
    expectFetch(32'h0000_3240, 1'b0, extWord(32'h0000_3240), "R9");

    // R10: disable hides lines, re-enable brings them back
    setBlk(1, 1'b0, 1'b0, 1'b0, 23'h0);
    setBlk(2, 1'b0, 1'b0, 1'b0, 23'h0);
    expectFetch(32'h0000_3240, 1'b0, extWord(32'h0000_3240), "R10");
    setBlk(1, 1'b0, 1'b1, 1'b0, 23'h0);
    setBlk(2, 1'b0, 1'b1, 1'b0, 23'h0);
    expectFetch(32'h0000_3240, 1'b1, extWord(32'h0000_3240), "R10");

    // R12: unaligned miss requests the aligned word; ready low throughout
    expectFetch(32'h0000_5007, 1'b0, extWord(32'h0000_5004), "R12");
    chk(lastRefill == 32'h0000_5004, "R12", "refillAddr", lastRefill, 32'h0000_5004);
    chk(readyBad == 0, "R12", "fetchReady during refill", 32'(readyBad), 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule